// File: doc/BRIEF.md
# Phase-Accumulator Pulse-Width Modulator with Shadowed Settings

This block drives a set of independent pulse-width outputs. Each output has its own control word. The word holds an enable flag, an update-request flag, a frequency increment and an 8-bit duty divisor. While a channel runs, its phase register advances by the active increment on every clock and wraps modulo 2^INC_W. The output frequency is therefore increment × f_clk / 2^INC_W. The output is high while the top eight phase bits lie below 255 minus the active divisor, so a larger divisor shortens the high time.

Software writes new settings into a shadow copy and sets the update-request flag. The channel moves the shadow increment and divisor into the active copy only at a period boundary, and the flag clears itself at that moment. A period boundary is the cycle in which the phase wraps. A running channel whose active increment is zero has no period in progress, so it takes the pending settings on the next clock. While a request is pending, a write may change only the enable flag. A build option, COMMIT_OFF, decides whether a disabled channel also takes a pending request.

The register bus is a plain, single-cycle select/write-enable bus with a combinational read. Channel c has its control word at byte address c × 0x400.

Top module: `pwm_acc_top`

## Requirements
- R1: After reset every control word reads zero, every output is low and no update is pending.
- R2: Layout of the control word: bit 31 is enable, bit 30 is update-request, bits [8+INC_W-1:8] are the shadow increment, and bits [7:0] are the shadow divisor. All other bits are ignored on write and read as zero. A read returns the shadow fields together with the live enable and update bits.
- R3: Channel c is decoded only at byte address c × 0x400, and only when c < NCH. A write to any other address changes nothing. A read of any other address, or a read made without bus_sel, returns zero.
- R4: On every clock an enabled channel adds its active increment to its phase, modulo 2^INC_W. The channel's output is high exactly when the top 8 phase bits are below 255 minus the active divisor.
- R5: An enabled channel whose active increment is zero keeps a constant output and does not toggle.
- R6: A channel with enable clear drives its output low from the cycle after the write. Its phase is held at zero, so the next enable starts from phase zero.
- R7: A pending update moves the shadow fields into the active copy, and the update bit clears, in one of two cases: in the clock where an enabled channel's phase wraps, or on the first clock of an enabled channel whose active increment is zero. Otherwise the update stays pending.
- R8: The active increment and divisor change only at a commit. Shadow values that are not yet committed do not affect the output.
- R9: While an update is pending, a write changes only the enable bit. The update bit, shadow increment and shadow divisor keep their values.
- R10: With COMMIT_OFF=1, a disabled channel with a pending update commits on the next clock. With COMMIT_OFF=0, the update stays pending for as long as the channel is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pwm_o | output | NCH | One pulse output per channel |

## Verification
The assertions assume that each bus access lasts exactly one clock. They also assume that reset is held until all state registers are zero, which makes every past value they look at a post-reset value. The stimulus drives each access between falling edges and releases reset on a falling edge. It always writes enable and update in a way that matches the rule under test, so a channel never enters a pending state that the chosen COMMIT_OFF variant cannot leave. The sweep of increment and divisor values starts each run from a zero phase, which makes the expected output a closed-form function of the cycle count.

// File: rtl/pwm_acc_pkg.sv
package pwm_acc_pkg;
  localparam int EN_BIT      = 31;
  localparam int UPD_BIT     = 30;
  localparam int INC_LSB     = 8;
  localparam int DIV_W       = 8;
  localparam int STRIDE_LOG2 = 10;

  // high while phase top byte is under the inverted divisor
  function automatic logic duty_high(input logic [DIV_W-1:0] phase_hi,
                                     input logic [DIV_W-1:0] divisor);
    return phase_hi < (8'hFF - divisor);
  endfunction
endpackage

// File: rtl/pwm_acc_phase.sv
module pwm_acc_phase #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] inc,
  output logic [W-1:0] phase,
  output logic         wrap
);
  logic [W:0] sum;

  assign sum  = {1'b0, phase} + {1'b0, inc};
  assign wrap = run & sum[W];

  always_ff @(posedge clk) begin
    if (!rst_n)   phase <= '0;
    else if (run) phase <= sum[W-1:0];
    else          phase <= '0;
  end
endmodule

// File: rtl/pwm_acc_channel.sv
module pwm_acc_channel
  import pwm_acc_pkg::*;
#(
  parameter int INC_W      = 10,
  parameter bit COMMIT_OFF = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_stb,
  input  logic [31:0]            wdata,
  output logic [31:0]            rdata,
  output logic                   pwm_o,
  output logic                   en_o,
  output logic                   upd_o,
  output logic [INC_W-1:0]       acc_o,
  output logic [INC_W-1:0]       inc_act_o,
  output logic [DIV_W-1:0]       div_act_o,
  output logic [INC_W+DIV_W-1:0] shd_o,
  output logic                   wrap_o,
  output logic                   commit_o
);
  localparam int PAD_W = 32 - 2 - INC_W - DIV_W;

  logic             en_q, upd_q;
  logic [INC_W-1:0] inc_sh_q, inc_act_q;
  logic [DIV_W-1:0] div_sh_q, div_act_q;
  logic [INC_W-1:0] phase;
  logic             wrap, idle, boundary, commit;
  logic             unused_pad;

  assign unused_pad = ^wdata[UPD_BIT-1:INC_LSB+INC_W];

  pwm_acc_phase #(.W(INC_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en_q),
    .inc   (inc_act_q),
    .phase (phase),
    .wrap  (wrap)
  );

  assign idle = (inc_act_q == '0);

  generate
    if (COMMIT_OFF) begin : g_off_commit
      assign boundary = en_q ? (wrap | idle) : 1'b1;
    end else begin : g_on_commit
      assign boundary = en_q & (wrap | idle);
    end
  endgenerate

  assign commit = upd_q & boundary;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      upd_q     <= 1'b0;
      inc_sh_q  <= '0;
      div_sh_q  <= '0;
      inc_act_q <= '0;
      div_act_q <= '0;
    end else begin
      if (wr_stb) begin
        en_q <= wdata[EN_BIT];
        if (!upd_q) begin
          upd_q    <= wdata[UPD_BIT];
          inc_sh_q <= wdata[INC_LSB +: INC_W];
          div_sh_q <= wdata[DIV_W-1:0];
        end
      end
      if (commit) begin
        inc_act_q <= inc_sh_q;
        div_act_q <= div_sh_q;
        upd_q     <= 1'b0;
      end
    end
  end

  assign pwm_o     = en_q & duty_high(phase[INC_W-1 -: DIV_W], div_act_q);
  assign rdata     = {en_q, upd_q, {PAD_W{1'b0}}, inc_sh_q, div_sh_q};
  assign en_o      = en_q;
  assign upd_o     = upd_q;
  assign acc_o     = phase;
  assign inc_act_o = inc_act_q;
  assign div_act_o = div_act_q;
  assign shd_o     = {inc_sh_q, div_sh_q};
  assign wrap_o    = wrap;
  assign commit_o  = commit;
endmodule

// File: rtl/pwm_acc_decode.sv
module pwm_acc_decode
  import pwm_acc_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 12
) (
  input  logic                          bus_sel,
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  output logic [NCH-1:0]                wr_stb,
  output logic                          rd_hit,
  output logic [ADDR_W-STRIDE_LOG2-1:0] rd_idx
);
  localparam int IDX_W = ADDR_W - STRIDE_LOG2;

  logic offset_ok, in_range, hit;

  assign rd_idx    = bus_addr[ADDR_W-1:STRIDE_LOG2];
  assign offset_ok = (bus_addr[STRIDE_LOG2-1:0] == '0);
  assign in_range  = (32'(rd_idx) < NCH);
  assign hit       = bus_sel & offset_ok & in_range;
  assign rd_hit    = hit & ~bus_we;

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_stb
      assign wr_stb[g] = hit & bus_we & (rd_idx == IDX_W'(g));
    end
  endgenerate
endmodule

// File: rtl/pwm_acc_top.sv
module pwm_acc_top
  import pwm_acc_pkg::*;
#(
  parameter int NCH        = 2,
  parameter int INC_W      = 10,
  parameter int ADDR_W     = 12,
  parameter bit COMMIT_OFF = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  localparam int IDX_W = ADDR_W - STRIDE_LOG2;

  logic [NCH-1:0]                   wr_stb;
  logic                             rd_hit;
  logic [IDX_W-1:0]                 rd_idx;
  logic [NCH-1:0][31:0]             ch_rdata;
  logic [NCH-1:0]                   ch_en, ch_upd, ch_wrap, ch_commit;
  logic [NCH-1:0][INC_W-1:0]        ch_acc, ch_inc_act;
  logic [NCH-1:0][DIV_W-1:0]        ch_div_act;
  logic [NCH-1:0][INC_W+DIV_W-1:0]  ch_shd;

  pwm_acc_decode #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .wr_stb   (wr_stb),
    .rd_hit   (rd_hit),
    .rd_idx   (rd_idx)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwm_acc_channel #(.INC_W(INC_W), .COMMIT_OFF(COMMIT_OFF)) u_ch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb[c]),
        .wdata     (bus_wdata),
        .rdata     (ch_rdata[c]),
        .pwm_o     (pwm_o[c]),
        .en_o      (ch_en[c]),
        .upd_o     (ch_upd[c]),
        .acc_o     (ch_acc[c]),
        .inc_act_o (ch_inc_act[c]),
        .div_act_o (ch_div_act[c]),
        .shd_o     (ch_shd[c]),
        .wrap_o    (ch_wrap[c]),
        .commit_o  (ch_commit[c])
      );
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NCH; c++) begin
      if (rd_hit && rd_idx == IDX_W'(c)) bus_rdata = ch_rdata[c];
    end
  end
endmodule

// File: rtl/pwm_acc_chk.sv
module pwm_acc_chk #(
  parameter int NCH        = 2,
  parameter int INC_W      = 10,
  parameter bit COMMIT_OFF = 1'b0
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NCH-1:0]             en,
  input logic [NCH-1:0]             upd,
  input logic [NCH-1:0]             wrap,
  input logic [NCH-1:0]             commit,
  input logic [NCH-1:0][INC_W-1:0]  acc,
  input logic [NCH-1:0][INC_W-1:0]  inc_act,
  input logic [NCH-1:0][7:0]        div_act,
  input logic [NCH-1:0][INC_W+7:0]  shd,
  input logic [NCH-1:0]             pwm
);
  generate
    for (genvar i = 0; i < NCH; i++) begin : g_chk
      // R9
      shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd[i] |=> shd[i] == $past(shd[i]));
      // R7
      pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd[i] && !commit[i]) |=> upd[i]);
      // R7
      commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit[i] |-> (!en[i] || wrap[i] || inc_act[i] == '0));
      // R7
      commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit[i] |=> !upd[i]);
      // R8
      active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit[i] |=> {inc_act[i], div_act[i]} == $past({inc_act[i], div_act[i]}));
      // R6
      off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[i] |-> !pwm[i]);
      // R6
      off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en[i] |=> acc[i] == '0);
      if (COMMIT_OFF) begin : g_off
        // R10
        off_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (upd[i] && !en[i]) |-> commit[i]);
      end else begin : g_on
        // R10
        off_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !en[i] |-> !commit[i]);
      end
    end
  endgenerate
endmodule

bind pwm_acc_top pwm_acc_chk #(.NCH(NCH), .INC_W(INC_W), .COMMIT_OFF(COMMIT_OFF)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (ch_en),
  .upd     (ch_upd),
  .wrap    (ch_wrap),
  .commit  (ch_commit),
  .acc     (ch_acc),
  .inc_act (ch_inc_act),
  .div_act (ch_div_act),
  .shd     (ch_shd),
  .pwm     (pwm_o)
);

// File: tb/tb_pwm_acc_top.sv
module tb_pwm_acc_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int INC_W = 8;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_a = 1'b0, sel_b = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata_a, rdata_b;
  logic [NCH-1:0] pwm_a, pwm_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_acc_top #(.NCH(NCH), .INC_W(INC_W), .ADDR_W(ADDR_W), .COMMIT_OFF(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_a), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_a), .pwm_o(pwm_a));

  pwm_acc_top #(.NCH(NCH), .INC_W(INC_W), .ADDR_W(ADDR_W), .COMMIT_OFF(1'b1)) dut_off (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel_b), .bus_we(we), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata_b), .pwm_o(pwm_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // called at a falling edge; write lands on the next rising edge
  task automatic wr(input int which, input logic [ADDR_W-1:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    if (which == 1) sel_b = 1'b1; else sel_a = 1'b1;
    @(posedge clk);
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b0; we = 1'b0;
  endtask

  task automatic rdchk(input int which, input logic [ADDR_W-1:0] a,
                       input logic [31:0] exp, input string req);
    addr = a; we = 1'b0;
    if (which == 1) sel_b = 1'b1; else sel_a = 1'b1;
    #1;
    check(req, (which == 1) ? rdata_b : rdata_a, exp);
    sel_a = 1'b0; sel_b = 1'b0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdchk(0, 12'h000, 32'h0, "R1");
    rdchk(0, 12'h400, 32'h0, "R1");
    rdchk(1, 12'h000, 32'h0, "R1");
    check("R1", {30'h0, pwm_a}, 32'h0);
    check("R1", {30'h0, pwm_b}, 32'h0);

    // R2 layout: junk in bits 29:16 dropped, fields read back
    wr(0, 12'h400, 32'hBFFF_5A33);
    rdchk(0, 12'h400, 32'h8000_5A33, "R2");
    // R3 channel isolation and address decode
    rdchk(0, 12'h000, 32'h0, "R3");
    wr(0, 12'h004, 32'hC000_1111);
    rdchk(0, 12'h000, 32'h0, "R3");
    rdchk(0, 12'h004, 32'h0, "R3");
    rdchk(0, 12'h800, 32'h0, "R3");
    addr = 12'h400; #1;
    check("R3 read without select", rdata_a, 32'h0);

    // R7 idle commit, R8 deferred divisor, R9 lockout, R4 new threshold
    wr(0, 12'h000, 32'hC000_4000);             // inc 64, div 0, phase 0
    rdchk(0, 12'h000, 32'hC000_4000, "R7");
    step();                                     // idle commit
    rdchk(0, 12'h000, 32'h8000_4000, "R7");
    wr(0, 12'h000, 32'hC000_20EF);             // inc 32, div 239 -> phase 64
    rdchk(0, 12'h000, 32'hC000_20EF, "R7");
    check("R8", pwm_a[0], 1'b1);
    step();                                     // phase 128
    check("R8", pwm_a[0], 1'b1);
    wr(0, 12'h000, 32'h8000_0107);             // ignored shadow -> phase 192
    check("R9", pwm_a[0], 1'b1);
    rdchk(0, 12'h000, 32'hC000_20EF, "R9");
    step();                                     // wrap, commit, phase 0
    rdchk(0, 12'h000, 32'h8000_20EF, "R7");
    check("R4", pwm_a[0], 1'b1);
    step();                                     // phase 32 with new inc
    check("R4", pwm_a[0], 1'b0);
    // R6 disable forces low
    wr(0, 12'h000, 32'h0000_20EF);
    check("R6", pwm_a[0], 1'b0);
    repeat (5) step();
    check("R6", pwm_a[0], 1'b0);
    rdchk(0, 12'h000, 32'h0000_20EF, "R6");

    // R10 with COMMIT_OFF=0: pending while disabled, enable-only write allowed
    wr(0, 12'h400, 32'h4000_0800);
    repeat (20) step();
    rdchk(0, 12'h400, 32'h4000_0800, "R10");
    wr(0, 12'h400, 32'h8000_0000);
    rdchk(0, 12'h400, 32'hC000_0800, "R9");
    step();
    rdchk(0, 12'h400, 32'h8000_0800, "R10");

    // R5 zero increment never toggles
    wr(1, 12'h400, 32'h4000_0064);
    step();
    wr(1, 12'h400, 32'h8000_0064);
    begin
      int bad = 0;
      for (int n = 0; n < 300; n++) begin
        if (pwm_b[1] !== 1'b1) bad++;
        step();
      end
      check("R5", bad, 0);
    end
    // R10 with COMMIT_OFF=1: disabled channel commits next clock
    wr(1, 12'h400, 32'h0000_0000);
    wr(1, 12'h400, 32'h4000_0800);
    rdchk(1, 12'h400, 32'h4000_0800, "R10");
    step();
    rdchk(1, 12'h400, 32'h0000_0800, "R10");

    // R4 sweep of increment and divisor from phase zero
    begin
      int incs[5] = '{1, 3, 64, 128, 255};
      int divs[5] = '{0, 1, 128, 254, 255};
      for (int a = 0; a < 5; a++) begin
        for (int b = 0; b < 5; b++) begin
          int bad = 0;
          wr(1, 12'h000, {2'b01, 14'h0, 8'(incs[a]), 8'(divs[b])});
          step();
          wr(1, 12'h000, {2'b10, 14'h0, 8'(incs[a]), 8'(divs[b])});
          for (int n = 0; n < 256; n++) begin
            logic e;
            e = ((n * incs[a]) % 256) < (255 - divs[b]);
            if (pwm_b[0] !== e) bad++;
            step();
          end
          check($sformatf("R4 inc=%0d div=%0d", incs[a], divs[b]), bad, 0);
          wr(1, 12'h000, 32'h0);
        end
      end
    end

    summary();
    $finish;
  end
endmodule